// File: doc/BRIEF.md
# Deductive Stuck-At Fault List Engine

This block works out, for one applied input pattern, which single stuck-at faults of a small built-in combinational netlist that pattern detects. It does not run a separate simulation for each faulty copy of the circuit. Each wire keeps two things: its fault-free value, and a bitmask of the faults that would flip that wire. The engine builds these masks with set algebra. For each gate the rule depends on the gate kind and on whether any input sits at the gate's controlling value.

A pattern and a fault-enable mask are offered with a valid/ready handshake. The engine first loads the primary-input wires. It then evaluates one gate per clock, in a fixed topological order. Finally it reports the union of the masks found on the primary outputs, together with a one-cycle done pulse. Only faults whose enable bit was set when the pattern was accepted can appear anywhere in the result.

Top module: `dfs_engine`

## Requirements
- R1: After reset, pat_ready is 1, done is 0 and detected is all zero.
- R2: A primary input at value v holds only its own stuck-at-(not v) fault, and holds it only when that fault is enabled.
- R3: When no input of an AND, OR, NAND or NOR gate is at the controlling value (0 for AND/NAND, 1 for OR/NOR), the output mask is the union of the input masks.
- R4: When one or more inputs are at the controlling value, the output mask is the intersection of the masks of the controlling inputs, with the masks of the non-controlling inputs removed.
- R5: A fanout branch copies its stem's mask and an inverter passes its input mask through. Every gate or branch then adds its own stuck-at fault for the inverse of its fault-free value.
- R6: A fault whose enable bit was 0 when the pattern was accepted never appears in detected. Changing fault_en while a sweep is running has no effect on that sweep.
- R7: detected equals exactly the set of enabled faults that change at least one primary output. The netlist uses these wires: w0, w1 and w2 are the inputs pat_in[0], pat_in[1] and pat_in[2]. w3 and w4 are fanout branches of w1. w5 = NAND(w0,w3), w6 = NOT(w4), w7 = OR(w6,w2), w8 = NOR(w5,w7) and w9 = AND(w5,w2). The primary outputs are w8 and w9. Fault number 2*k+s is wire wk stuck at s.
- R8: done rises in the cycle that follows the 8th rising edge after the accepting edge (the edge where pat_valid and pat_ready are both 1). It stays high for exactly one cycle, and detected changes only when done rises.
- R9: pat_ready is 0 from the accepting edge until done is asserted. A pattern offered while pat_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_valid | input | 1 | A pattern is offered |
| pat_ready | output | 1 | Engine idle, the offered pattern is taken on this edge |
| pat_in | input | 3 | Primary input values, bit k drives wire wk |
| fault_en | input | 20 | Enable bit per fault, bit 2*k+s is wire wk stuck at s |
| done | output | 1 | One-cycle pulse marking a fresh result |
| detected | output | 20 | Enabled faults detected by the last pattern |

## Verification
Several properties are checked on every cycle: the done pulse lasts one cycle, the gap from acceptance to done is fixed, pat_ready stays low while a sweep runs, detected changes only as done rises, and the result never includes a fault outside the latched enable mask. Whether the set algebra gives the right faults can only be shown by the bench scenarios. These cover every input pattern with all faults enabled, with no faults enabled, and with each fault enabled on its own. Each result is compared with a brute-force fault injection, and a conflicting pattern and mask are offered in the middle of every sweep.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

   localparam int NUM_PI    = 3;
   localparam int NUM_WIRE  = 10;
   localparam int NUM_FAULT = 2 * NUM_WIRE;
   localparam int WIRE_W    = $clog2(NUM_WIRE);

   typedef enum logic [2:0] {
      K_PI, K_BUF, K_NOT, K_AND, K_OR, K_NAND, K_NOR
   } node_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE, ST_SWEEP, ST_FIN
   } sweep_st_e;

   typedef struct packed {
      node_kind_e        kind;
      logic [WIRE_W-1:0] src_a;
      logic [WIRE_W-1:0] src_b;
   } node_t;

   // primary outputs are wires 8 and 9
   localparam logic [NUM_WIRE-1:0] PO_MASK = NUM_WIRE'(10'b11_0000_0000);

   // topologically ordered netlist, one node per wire index
   function automatic node_t node_of(input int idx);
      node_t n;
      n = '{kind: K_PI, src_a: '0, src_b: '0};
      case (idx)
         3: n = '{kind: K_BUF,  src_a: WIRE_W'(1), src_b: WIRE_W'(1)};
         4: n = '{kind: K_BUF,  src_a: WIRE_W'(1), src_b: WIRE_W'(1)};
         5: n = '{kind: K_NAND, src_a: WIRE_W'(0), src_b: WIRE_W'(3)};
         6: n = '{kind: K_NOT,  src_a: WIRE_W'(4), src_b: WIRE_W'(4)};
         7: n = '{kind: K_OR,   src_a: WIRE_W'(6), src_b: WIRE_W'(2)};
         8: n = '{kind: K_NOR,  src_a: WIRE_W'(5), src_b: WIRE_W'(7)};
         9: n = '{kind: K_AND,  src_a: WIRE_W'(5), src_b: WIRE_W'(2)};
         default: ;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dfs_gate_rule.sv
module dfs_gate_rule
   import dfs_pkg::*;
#(
   parameter int FAULT_N = NUM_FAULT,
   parameter int IDX_W   = WIRE_W
) (
   input  node_kind_e         kind,
   input  logic               val_a,
   input  logic               val_b,
   input  logic [FAULT_N-1:0] list_a,
   input  logic [FAULT_N-1:0] list_b,
   input  logic [IDX_W-1:0]   own_idx,
   input  logic [FAULT_N-1:0] en,
   output logic               val_out,
   output logic [FAULT_N-1:0] list_out
);

   logic               ctrl_v;
   logic               inv;
   logic               a_c;
   logic               b_c;
   logic [FAULT_N-1:0] prop;
   logic [FAULT_N-1:0] own_bit;

   always_comb begin
      ctrl_v = (kind == K_OR) || (kind == K_NOR);
      inv    = (kind == K_NAND) || (kind == K_NOR) || (kind == K_NOT);
      a_c    = (val_a == ctrl_v);
      b_c    = (val_b == ctrl_v);
      if (kind == K_BUF || kind == K_NOT) begin
         val_out = val_a ^ inv;
         prop    = list_a;
      end else if (!a_c && !b_c) begin
         val_out = ~ctrl_v ^ inv;
         prop    = list_a | list_b;
      end else if (a_c && b_c) begin
         val_out = ctrl_v ^ inv;
         prop    = list_a & list_b;
      end else if (a_c) begin
         val_out = ctrl_v ^ inv;
         prop    = list_a & ~list_b;
      end else begin
         val_out = ctrl_v ^ inv;
         prop    = list_b & ~list_a;
      end
      own_bit = '0;
      own_bit[2 * int'(own_idx) + (val_out ? 0 : 1)] = 1'b1;
      list_out = prop | (own_bit & en);
   end

endmodule

// File: rtl/dfs_node_store.sv
module dfs_node_store
   import dfs_pkg::*;
#(
   parameter int PI_N    = NUM_PI,
   parameter int WIRE_N  = NUM_WIRE,
   parameter int FAULT_N = 2 * WIRE_N,
   parameter int IDX_W   = $clog2(WIRE_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PI_N-1:0]    pat,
   input  logic [FAULT_N-1:0] en,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_val,
   input  logic [FAULT_N-1:0] wr_list,
   output logic [WIRE_N-1:0]  val_q,
   output logic [FAULT_N-1:0] list_q [WIRE_N]
);

   localparam logic [FAULT_N-1:0] ONE = FAULT_N'(1);

   for (genvar i = 0; i < WIRE_N; i++) begin : g_wire
      if (i < PI_N) begin : g_pi
         localparam logic [FAULT_N-1:0] SA0_BIT = ONE << (2 * i);
         localparam logic [FAULT_N-1:0] SA1_BIT = ONE << (2 * i + 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q[i]  <= 1'b0;
               list_q[i] <= '0;
            end else if (load) begin
               val_q[i]  <= pat[i];
               list_q[i] <= en & (pat[i] ? SA0_BIT : SA1_BIT);
            end
         end
      end else begin : g_gate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q[i]  <= 1'b0;
               list_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
               val_q[i]  <= wr_val;
               list_q[i] <= wr_list;
            end
         end
      end
   end

endmodule

// File: rtl/dfs_sweep_ctrl.sv
module dfs_sweep_ctrl
   import dfs_pkg::*;
#(
   parameter int PI_N   = NUM_PI,
   parameter int WIRE_N = NUM_WIRE,
   parameter int IDX_W  = $clog2(WIRE_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_valid,
   output logic             pat_ready,
   output logic             accept,
   output logic             wr_en,
   output logic             fin,
   output logic [IDX_W-1:0] step
);

   localparam logic [IDX_W-1:0] FIRST = IDX_W'(PI_N);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(WIRE_N - 1);

   sweep_st_e state;

   assign pat_ready = (state == ST_IDLE);
   assign accept    = pat_valid && pat_ready;
   assign wr_en     = (state == ST_SWEEP);
   assign fin       = (state == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         step  <= FIRST;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state <= ST_SWEEP;
               step  <= FIRST;
            end
            ST_SWEEP: if (step == LAST) state <= ST_FIN;
                      else              step  <= step + 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dfs_engine.sv
module dfs_engine
   import dfs_pkg::*;
#(
   parameter int PI_N    = NUM_PI,
   parameter int WIRE_N  = NUM_WIRE,
   parameter int FAULT_N = 2 * WIRE_N
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pat_valid,
   output logic               pat_ready,
   input  logic [PI_N-1:0]    pat_in,
   input  logic [FAULT_N-1:0] fault_en,
   output logic               done,
   output logic [FAULT_N-1:0] detected
);

   localparam int IDX_W = $clog2(WIRE_N);

   if (FAULT_N > 32)            $error("fault universe limited to 32 entries");
   if (WIRE_N != NUM_WIRE)      $error("WIRE_N must match the built-in netlist");
   if (PI_N != NUM_PI)          $error("PI_N must match the built-in netlist");
   if (FAULT_N != 2 * WIRE_N)   $error("FAULT_N must be two per wire");
   if (IDX_W != WIRE_W)         $error("index width mismatch");

   logic               accept;
   logic               wr_en;
   logic               fin;
   logic [IDX_W-1:0]   step;
   logic [WIRE_N-1:0]  val_q;
   logic [FAULT_N-1:0] list_q [WIRE_N];
   logic [FAULT_N-1:0] en_q;
   logic               g_val;
   logic [FAULT_N-1:0] g_list;
   logic [FAULT_N-1:0] po_union;
   node_t              nd;

   assign nd = node_of(int'(step));

   dfs_sweep_ctrl #(.PI_N(PI_N), .WIRE_N(WIRE_N), .IDX_W(IDX_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
      .accept(accept), .wr_en(wr_en), .fin(fin), .step(step)
   );

   dfs_node_store #(.PI_N(PI_N), .WIRE_N(WIRE_N), .FAULT_N(FAULT_N), .IDX_W(IDX_W)) i_store (
      .clk(clk), .rst_n(rst_n), .load(accept), .pat(pat_in), .en(fault_en),
      .wr_en(wr_en), .wr_idx(step), .wr_val(g_val), .wr_list(g_list),
      .val_q(val_q), .list_q(list_q)
   );

   dfs_gate_rule #(.FAULT_N(FAULT_N), .IDX_W(IDX_W)) i_rule (
      .kind(nd.kind), .val_a(val_q[nd.src_a]), .val_b(val_q[nd.src_b]),
      .list_a(list_q[nd.src_a]), .list_b(list_q[nd.src_b]),
      .own_idx(step), .en(en_q), .val_out(g_val), .list_out(g_list)
   );

   always_comb begin
      po_union = '0;
      for (int i = 0; i < WIRE_N; i++)
         if (PO_MASK[i]) po_union = po_union | list_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         done     <= 1'b0;
         detected <= '0;
      end else begin
         if (accept) en_q <= fault_en;
         done <= fin;
         if (fin) detected <= po_union;
      end
   end

endmodule

// File: rtl/dfs_engine_chk.sv
module dfs_engine_chk #(
   parameter int FAULT_N = 20,
   parameter int GATE_N  = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pat_valid,
   input logic               pat_ready,
   input logic               done,
   input logic [FAULT_N-1:0] detected,
   input logic [FAULT_N-1:0] en_q
);

   localparam logic [7:0] LAT = 8'(GATE_N + 1);

   logic [7:0] cnt;
   logic       act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         act <= 1'b0;
      end else if (pat_valid && pat_ready) begin
         cnt <= '0;
         act <= 1'b1;
      end else if (done) begin
         act <= 1'b0;
      end else if (act) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                          // R8
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (act && cnt == LAT));                            // R8
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_valid && pat_ready) |=> !pat_ready);                 // R9
   AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pat_ready);                                      // R9
   AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(detected) |-> $rose(done));                      // R8
   AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((detected & ~en_q) == '0));                     // R6

endmodule

bind dfs_engine dfs_engine_chk #(.FAULT_N(FAULT_N), .GATE_N(WIRE_N - PI_N)) i_chk (
   .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
   .done(done), .detected(detected), .en_q(en_q)
);

// File: tb/test_dfs_engine.sv
module test_dfs_engine;

   localparam int CLK_PERIOD = 10;
   localparam int NPI = 3;
   localparam int NF  = 20;
   localparam int LAT = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pat_valid = 1'b0;
   logic          pat_ready;
   logic [NPI-1:0] pat_in = '0;
   logic [NF-1:0] fault_en = '0;
   logic          done;
   logic [NF-1:0] detected;

   int n_run = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dfs_engine i_dfs_engine (
      .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
      .pat_in(pat_in), .fault_en(fault_en), .done(done), .detected(detected)
   );

   // brute-force evaluation of the netlist of R7 with an optional injected fault
   function automatic logic [1:0] po_eval(input logic [2:0] p, input int f);
      logic w [10];
      for (int k = 0; k < 10; k++) begin
         case (k)
            0: w[k] = p[0];
            1: w[k] = p[1];
            2: w[k] = p[2];
            3: w[k] = w[1];
            4: w[k] = w[1];
            5: w[k] = ~(w[0] & w[3]);
            6: w[k] = ~w[4];
            7: w[k] = w[6] | w[2];
            8: w[k] = ~(w[5] | w[7]);
            default: w[k] = w[5] & w[2];
         endcase
         if (f >= 0 && f / 2 == k) w[k] = (f % 2 == 1);
      end
      return {w[9], w[8]};
   endfunction

   function automatic logic [NF-1:0] expect_det(input logic [2:0] p, input logic [NF-1:0] en);
      logic [NF-1:0] r = '0;
      for (int f = 0; f < NF; f++)
         if (en[f] && po_eval(p, f) != po_eval(p, -1)) r[f] = 1'b1;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [2:0] p, input logic [NF-1:0] en);
      int idx;
      logic [NF-1:0] exp_d;
      exp_d = expect_det(p, en);
      @(negedge clk);
      pat_valid = 1'b1;
      pat_in    = p;
      fault_en  = en;
      check(pat_ready == 1'b1, "R9 ready when idle", 32'(pat_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      // conflicting offer while busy must be ignored (R9, R6)
      pat_in   = ~p;
      fault_en = ~en;
      check(pat_ready == 1'b0, "R9 busy after accept", 32'(pat_ready), 32'd0);
      idx = 0;
      while (!done && idx < 30) begin
         if (idx >= 5) pat_valid = 1'b0;
         @(negedge clk);
         idx++;
      end
      pat_valid = 1'b0;
      check(idx == LAT, "R8 latency", 32'(idx), 32'(LAT));
      check(detected == exp_d, "R2 R3 R4 R5 R6 R7 detected set", 32'(detected), 32'(exp_d));
      @(negedge clk);
      check(done == 1'b0, "R8 single-cycle done", 32'(done), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_run++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pat_ready == 1'b1, "R1 reset ready", 32'(pat_ready), 32'd1);
      check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
      check(detected == '0, "R1 reset detected", 32'(detected), 32'd0);
      rst_n = 1'b1;
      for (int m = 0; m < NF + 2; m++) begin
         logic [NF-1:0] mask;
         if (m == 0)      mask = '1;
         else if (m == 1) mask = '0;
         else             mask = NF'(1) << (m - 2);
         for (int p = 0; p < 8; p++) run_one(3'(p), mask);
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule